// File: doc/BRIEF.md
# Waveform Amplitude Memory Loader

This block sits behind the host's byte-wide register port. It watches the stream of received bytes for the three-byte sequence that loads the small amplitude memory used by transmit pulse shaping. First comes a command byte that selects register 0x13. The next byte is a memory location, and the byte after that is the amplitude value. When the sequence completes with a legal location, the value is written into an internal 42-entry by 8-bit memory.

The pulse shaping logic reads the memory through a separate, always-available read port. An error flag reports that a sequence named a location outside the memory; that flag stays set. A synchronous abort input abandons a sequence part-way through, so a broken host transfer cannot leave a half-finished write pending.

Top module: `wfl_loader`

## Requirements
- R1: After reset every memory location reads 0x00, `err_o` is low and the sequencer waits for a command byte.
- R2: While waiting for a command, a valid byte equal to 0x13 starts a sequence. Any other valid byte is ignored and writes nothing.
- R3: In a sequence, the valid byte after the command is taken as the location. The valid byte after that is the data, and it is written to that location. The new value appears on `rd_data` from the first clock edge after the data byte is accepted, and the sequencer then waits for a new command.
- R4: Locations 0x00 through 0x29 (42 entries) are storage. A `rd_addr` above 0x29 reads 0x00.
- R5: A location byte above 0x29 sets `err_o`. The data byte that follows is consumed without writing any location.
- R6: Once set, `err_o` stays high until reset and does not block later sequences.
- R7: `abort_i` high at a clock edge returns the sequencer to waiting for a command with no write. This holds even when a valid data byte is presented in the same cycle.
- R8: Cycles with `byte_vld` low do not advance the sequence, however many occur between the bytes of a sequence.
- R9: A location or data byte whose value is 0x13 is treated as location or data, not as a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Strobe: `byte_in` holds a received byte this cycle |
| byte_in | input | 8 | Received byte |
| abort_i | input | 1 | Synchronous abort of the current sequence |
| rd_addr | input | 6 | Read location for pulse shaping |
| rd_data | output | 8 | Stored amplitude at `rd_addr` (combinational) |
| err_o | output | 1 | Sticky out-of-range location flag |

## Verification
The main stimulus is a seeded random byte stream. Command bytes are weighted so that complete sequences occur often, and it mixes in gaps, stray non-command bytes, out-of-range locations and aborts. A bench model predicts every write and the error flag. This separates correct sequencing from off-by-one-byte sequencing, where the wrong byte lands as data or location. Directed cases add three things: the last legal location 0x29 and the first illegal one 0x2A, which separate the range bound from an off-by-one compare; an abort that collides with a data byte, which shows abort priority; and a 0x13 value used as location and data, which shows a mid-sequence byte is never mistaken for a command.

// File: rtl/wfl_pkg.sv
package wfl_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_CMD  = 2'd1,
      SQ_ADDR = 2'd2
   } seq_state_t;
endpackage

// File: rtl/wfl_seq.sv
module wfl_seq
   import wfl_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 6,
   parameter int DEPTH    = 42,
   parameter int CMD_CODE = 8'h13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [DW-1:0] din,
   input  logic          abort,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          err
);
   localparam logic [DW-1:0] CMD_BYTE  = DW'(CMD_CODE);
   localparam logic [DW-1:0] LAST_LOC  = DW'(DEPTH - 1);

   generate
      if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("wfl_seq: DEPTH does not fit AW");
      end
      if (AW > DW) begin : g_bad_aw
         $error("wfl_seq: AW wider than byte");
      end
   endgenerate

   seq_state_t    state_q, state_d;
   logic [AW-1:0] addr_q;
   logic          bad_q;
   logic          err_q;
   logic          loc_bad;

   assign loc_bad = (din > LAST_LOC);

   always_comb begin
      state_d = state_q;
      if (abort) begin
         state_d = SQ_IDLE;
      end else if (vld) begin
         unique case (state_q)
            SQ_IDLE: if (din == CMD_BYTE) state_d = SQ_CMD;
            SQ_CMD:  state_d = SQ_ADDR;
            SQ_ADDR: state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         addr_q  <= '0;
         bad_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!abort && vld && state_q == SQ_CMD) begin
            addr_q <= din[AW-1:0];
            bad_q  <= loc_bad;
            if (loc_bad) err_q <= 1'b1;
         end
      end
   end

   assign wr_en   = (state_q == SQ_ADDR) && vld && !abort && !bad_q;
   assign wr_addr = addr_q;
   assign wr_data = din;
   assign err     = err_q;

   // R1: legal state encoding only
   a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      state_q inside {SQ_IDLE, SQ_CMD, SQ_ADDR});
   // R7: abort always lands in idle
   a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> state_q == SQ_IDLE);
   // R6: error flag is sticky
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R8: no strobe, no movement
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !abort) |=> $stable(state_q));
   // R2: stray byte in idle keeps idle
   a_r2_stray: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && vld && !abort && din != CMD_BYTE) |=> state_q == SQ_IDLE);
   // R5: writes only target storage
   a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/wfl_ram.sv
module wfl_ram #(
   parameter int DW     = 8,
   parameter int AW     = 6,
   parameter int DEPTH  = 42,
   parameter bit REG_RD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   localparam int ROWS = 1 << AW;

   generate
      if (DEPTH > ROWS) begin : g_bad_depth
         $error("wfl_ram: DEPTH exceeds address space");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && int'(wa) < DEPTH) begin
         mem[wa] <= wd;
      end
   end

   always_comb begin
      rd_raw = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(ra) == i) rd_raw = mem[i];
      end
   end

   generate
      if (REG_RD) begin : g_rd_reg
         logic [DW-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_raw;
         end
         assign rd = rd_q;
      end else begin : g_rd_comb
         assign rd = rd_raw;
      end
   endgenerate

   // R3: written value is held in the addressed row
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(wa) < DEPTH) |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/wfl_loader.sv
module wfl_loader #(
   parameter int DW       = 8,
   parameter int AW       = 6,
   parameter int DEPTH    = 42,
   parameter int CMD_CODE = 8'h13,
   parameter bit REG_RD   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_in,
   input  logic          abort_i,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          err_o
);
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   wfl_seq #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CMD_CODE(CMD_CODE)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (byte_vld),
      .din     (byte_in),
      .abort   (abort_i),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .err     (err_o)
   );

   wfl_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .REG_RD(REG_RD)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .wa    (wr_addr),
      .wd    (wr_data),
      .ra    (rd_addr),
      .rd    (rd_data)
   );
endmodule

// File: tb/test_wfl_loader.sv
module test_wfl_loader;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 42;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = '0;
   logic       abort_i = 1'b0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       err_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] exp_mem [DEPTH];
   int  m_state;
   int  m_addr;
   bit  m_bad;
   bit  m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   wfl_loader i_wfl_loader (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .abort_i(abort_i), .rd_addr(rd_addr), .rd_data(rd_data), .err_o(err_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      return (a < DEPTH) ? exp_mem[a] : 8'h00;
   endfunction

   function automatic void model(input bit v, input logic [7:0] d, input bit a);
      if (a) m_state = 0;
      else if (v) begin
         case (m_state)
            0: if (d == 8'h13) m_state = 1;
            1: begin
               m_addr = d; m_bad = (d > 8'h29);
               if (m_bad) m_err = 1'b1;
               m_state = 2;
            end
            default: begin
               if (!m_bad) exp_mem[m_addr] = d;
               m_state = 0;
            end
         endcase
      end
   endfunction

   task automatic reset_all();
      @(negedge clk);
      rst_n = 1'b0; byte_vld = 1'b0; abort_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
      m_state = 0; m_addr = 0; m_bad = 1'b0; m_err = 1'b0;
   endtask

   task automatic step(input bit v, input logic [7:0] d, input bit a);
      @(negedge clk);
      byte_vld = v; byte_in = d; abort_i = a;
      model(v, d, a);
      @(negedge clk);
      byte_vld = 1'b0; abort_i = 1'b0;
   endtask

   task automatic peek(input string req, input int a);
      rd_addr = 6'(a);
      #1;
      chk(req, rd_data, exp_rd(a));
   endtask

   task automatic seq3(input logic [7:0] loc, input logic [7:0] dat);
      step(1'b1, 8'h13, 1'b0);
      step(1'b1, loc, 1'b0);
      step(1'b1, dat, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      reset_all();
      // R1 reset state
      chk("R1 err", err_o, 0);
      for (int i = 0; i < 64; i++) peek("R1/R4 reset contents", i);

      // R3 / R4 last legal location, first location
      seq3(8'h29, 8'hA5);
      peek("R3 loc 0x29", 8'h29);
      seq3(8'h00, 8'h3C);
      peek("R3 loc 0x00", 0);
      chk("R5 no err on legal", err_o, 0);

      // R9 0x13 as location and data
      seq3(8'h13, 8'h13);
      peek("R9 loc 0x13", 8'h13);

      // R2 stray bytes in idle
      step(1'b1, 8'h55, 1'b0);
      step(1'b1, 8'h05, 1'b0);
      step(1'b1, 8'h77, 1'b0);
      peek("R2 stray no write", 5);
      seq3(8'h06, 8'h61);
      peek("R2 still accepts command", 6);

      // R8 gaps between bytes
      step(1'b1, 8'h13, 1'b0);
      step(1'b0, 8'h13, 1'b0);
      step(1'b0, 8'h09, 1'b0);
      step(1'b1, 8'h07, 1'b0);
      step(1'b0, 8'hEE, 1'b0);
      step(1'b1, 8'h4D, 1'b0);
      peek("R8 gapped sequence", 7);

      // R7 abort colliding with data
      step(1'b1, 8'h13, 1'b0);
      step(1'b1, 8'h08, 1'b0);
      step(1'b1, 8'hD2, 1'b1);
      peek("R7 abort blocks write", 8);
      step(1'b1, 8'h08, 1'b0);
      peek("R7 back in idle", 8);
      step(1'b1, 8'h13, 1'b0);
      step(1'b0, 8'h00, 1'b1);
      seq3(8'h0A, 8'h99);
      peek("R7 abort after cmd then fresh seq", 10);

      // R5 / R6 out of range
      seq3(8'h2A, 8'hF0);
      chk("R5 err set", err_o, 1);
      for (int i = 0; i < DEPTH; i++) peek("R5 no write on bad loc", i);
      seq3(8'h0B, 8'h12);
      peek("R6 seq works after err", 11);
      chk("R6 err sticky", err_o, 1);

      // random stream
      for (int k = 0; k < 3000; k++) begin
         int r = $urandom_range(0, 99);
         logic [7:0] b;
         bit v = (r < 85);
         bit a = ($urandom_range(0, 99) < 4);
         if (m_state == 0 && $urandom_range(0, 2) != 0) b = 8'h13;
         else if (m_state == 1 && $urandom_range(0, 9) != 0) b = 8'($urandom_range(0, DEPTH - 1));
         else b = 8'($urandom_range(0, 255));
         step(v, b, a);
         chk("R5/R6 err random", err_o, m_err);
         peek("R3 random read", $urandom_range(0, 63));
      end
      for (int i = 0; i < 64; i++) peek("R3/R4 final sweep", i);

      reset_all();
      chk("R6 err cleared by reset", err_o, 0);
      peek("R1 contents cleared", 11);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule